// File: doc/BRIEF.md
# DRAM Strobe Sequencer with Refresh Insertion

This block drives the row strobe, the column strobe and the row/column address-multiplexer select of a DRAM that a processor and a video controller share. It runs on a sequencing clock that gives sixteen ticks per period of the CPU phase clock. Each tick is half a dot-clock period. The processor owns the half-period in which the phase clock is high. In that half, the block first issues a refresh in which the column strobe falls before the row strobe. After a short precharge gap, it runs an ordinary access in which the row strobe falls first and the column strobe follows.

In the other half of the phase period, the video controller's own strobes and select are copied to the outputs. The video controller may also take the processor half by raising the cycle-steal flag. The block samples this flag only at the start of each half. If the flag is set at the start of the processor half, the generated sequence is dropped for that half and the video strobes pass through instead. A sequence that has started is never cut short.

After reset the outputs stay idle until the first low-to-high transition of the phase clock is seen.

Top module: `dram_strobe_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, ras_n and cas_n are 1 and col_sel is 0 (row).
- R2: After reset, ras_n and cas_n stay 1 and col_sel stays 0 until a rising edge of phi is sampled (phi 0 then 1 on successive clocks). The video inputs have no effect before then, and phi held high through reset is not treated as a rising edge.
- R3: The clock edge that samples the phi rise is tick 0. Tick t of the processor half appears on the outputs after edge t+1. At tick 0 cas_n=0 and ras_n=1. At ticks 1 and 2 both strobes are 0. The column strobe therefore leads the row strobe.
- R4: At tick 3 both strobes are 1, which gives a precharge gap between the refresh and the access.
- R5: Ticks 4 to 7 are the processor access. At tick 4 ras_n=0, cas_n=1, col_sel=0. At tick 5 ras_n=0, cas_n=1, col_sel=1. At tick 6 ras_n=0, cas_n=0, col_sel=1. At tick 7 ras_n=1, cas_n=1, col_sel=0.
- R6: col_sel is 0 throughout the refresh ticks 0 to 3.
- R7: In the half where phi is low (ticks 8 to 15), ras_n, cas_n and col_sel equal vid_ras_n, vid_cas_n and vid_col as sampled on the previous clock edge.
- R8: If steal is 1 on the edge that samples the phi rise, the whole processor half passes the video inputs through, with the same one-edge latency as R7.
- R9: steal is sampled only at tick 0 and at the tick 7 to tick 8 boundary. A change of steal during a half does not alter that half's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock, two ticks per dot-clock period |
| rst | input | 1 | Synchronous active-high reset |
| phi | input | 1 | CPU phase clock; high half belongs to the processor |
| steal | input | 1 | Video controller is stealing the processor half |
| vid_ras_n | input | 1 | Video controller row strobe, active low |
| vid_cas_n | input | 1 | Video controller column strobe, active low |
| vid_col | input | 1 | Video controller address select, 1 = column |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| col_sel | output | 1 | Address multiplexer select, 1 = column |

## Verification
The assertions assume that phi is a regular square wave: eight clocks high, then eight clocks low, with each rise landing where the tick counter wraps. They also assume that reset is high from time zero. The bench drives phi only in whole periods of that shape, and it changes steal only on the falling clock edge. This lets the mid-half steal changes of R9 probe the sampling points without ever breaking the phase pattern. The video inputs come from a free-running shift register, so the pass-through checks see both values on every strobe.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic col;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, col: 1'b0};

    // Number of ticks the generated refresh+access sequence occupies.
    localparam int unsigned SEQ_LEN = 8;

    // Strobe levels for each tick of the processor half.
    function automatic strobe_t proc_pattern(input int unsigned t);
        strobe_t s;
        s = STROBE_IDLE;
        case (t)
            0: s = '{ras_n: 1'b1, cas_n: 1'b0, col: 1'b0}; // refresh: column strobe leads
            1: s = '{ras_n: 1'b0, cas_n: 1'b0, col: 1'b0};
            2: s = '{ras_n: 1'b0, cas_n: 1'b0, col: 1'b0};
            3: s = STROBE_IDLE;                            // precharge gap
            4: s = '{ras_n: 1'b0, cas_n: 1'b1, col: 1'b0}; // row strobe with row address
            5: s = '{ras_n: 1'b0, cas_n: 1'b1, col: 1'b1}; // switch to column address
            6: s = '{ras_n: 1'b0, cas_n: 1'b0, col: 1'b1}; // column strobe
            default: s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dss_phase_tracker.sv
module dss_phase_tracker #(
    parameter int HALF_TICKS = 8,
    parameter int CW         = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          phi,
    input  logic          steal,
    output logic [CW-1:0] tick,
    output logic          started,
    output logic          steal_lat
);
    localparam logic [CW-1:0] LAST_PROC = CW'(HALF_TICKS - 1);

    logic phi_q;
    logic rise;

    assign rise = phi & ~phi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phi_q     <= 1'b1;   // a phase already high at reset is not a rise
            tick      <= '0;
            started   <= 1'b0;
            steal_lat <= 1'b0;
        end else begin
            phi_q <= phi;
            if (rise) begin
                tick      <= '0;
                started   <= 1'b1;
                steal_lat <= steal;
            end else begin
                tick <= tick + 1'b1;
                if (tick == LAST_PROC) begin
                    steal_lat <= steal;
                end
            end
        end
    end
endmodule

// File: rtl/dss_pattern_gen.sv
module dss_pattern_gen
    import dss_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [CW-1:0] tick,
    output strobe_t       pat
);
    always_comb begin
        pat = proc_pattern(int'(unsigned'(tick)));
    end
endmodule

// File: rtl/dss_strobe_out.sv
module dss_strobe_out
    import dss_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    started,
    input  logic    gen,
    input  strobe_t pat,
    input  strobe_t vid,
    output strobe_t q
);
    always_ff @(posedge clk) begin
        if (rst || !started) begin
            q <= STROBE_IDLE;
        end else if (gen) begin
            q <= pat;
        end else begin
            q <= vid;
        end
    end
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dss_pkg::*;
#(
    parameter int HALF_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic phi,
    input  logic steal,
    input  logic vid_ras_n,
    input  logic vid_cas_n,
    input  logic vid_col,
    output logic ras_n,
    output logic cas_n,
    output logic col_sel
);
    localparam int CW = $clog2(2 * HALF_TICKS);
    localparam logic [CW-1:0] HALF_END = CW'(HALF_TICKS);

    logic [CW-1:0] tick_q;
    logic          started_q;
    logic          steal_q;
    logic          gen;
    strobe_t       pat;
    strobe_t       vid;
    strobe_t       drv;

    dss_phase_tracker #(.HALF_TICKS(HALF_TICKS), .CW(CW)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .phi       (phi),
        .steal     (steal),
        .tick      (tick_q),
        .started   (started_q),
        .steal_lat (steal_q)
    );

    dss_pattern_gen #(.CW(CW)) u_pat (
        .tick (tick_q),
        .pat  (pat)
    );

    assign gen = (tick_q < HALF_END) && !steal_q;
    assign vid = '{ras_n: vid_ras_n, cas_n: vid_cas_n, col: vid_col};

    dss_strobe_out u_out (
        .clk     (clk),
        .rst     (rst),
        .started (started_q),
        .gen     (gen),
        .pat     (pat),
        .vid     (vid),
        .q       (drv)
    );

    assign ras_n   = drv.ras_n;
    assign cas_n   = drv.cas_n;
    assign col_sel = drv.col;
endmodule

// File: rtl/dss_strobe_checker.sv
module dss_strobe_checker #(
    parameter int HALF_TICKS = 8,
    parameter int CW         = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          vid_ras_n,
    input logic          vid_cas_n,
    input logic          vid_col,
    input logic          ras_n,
    input logic          cas_n,
    input logic          col_sel,
    input logic [CW-1:0] tick,
    input logic          started,
    input logic          steal_lat
);
    logic in_gen;
    assign in_gen = started && (tick < CW'(HALF_TICKS)) && !steal_lat;

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ras_n && cas_n && !col_sel));

    p_wait_first_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!started) |-> (ras_n && cas_n && !col_sel));

    p_cas_leads_ras_r3: assert property (@(posedge clk) disable iff (rst)
        $past(in_gen && tick == CW'(1)) |-> (!ras_n && !cas_n && $past(ras_n) && !$past(cas_n)));

    p_precharge_gap_r4: assert property (@(posedge clk) disable iff (rst)
        $past(in_gen && tick == CW'(3)) |-> (ras_n && cas_n));

    p_col_before_cas_r5: assert property (@(posedge clk) disable iff (rst)
        $past(in_gen && tick == CW'(6)) |-> (!ras_n && !cas_n && col_sel && $past(col_sel)));

    p_row_in_refresh_r6: assert property (@(posedge clk) disable iff (rst)
        $past(in_gen && tick < CW'(4)) |-> !col_sel);

    p_pass_through_r7: assert property (@(posedge clk) disable iff (rst)
        $past(started && !in_gen) |->
            (ras_n == $past(vid_ras_n) && cas_n == $past(vid_cas_n) && col_sel == $past(vid_col)));

    p_steal_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(tick) != CW'(HALF_TICKS - 1) && tick != '0) |-> $stable(steal_lat));
endmodule

bind dram_strobe_seq dss_strobe_checker #(.HALF_TICKS(HALF_TICKS), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vid_ras_n (vid_ras_n),
    .vid_cas_n (vid_cas_n),
    .vid_col   (vid_col),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .col_sel   (col_sel),
    .tick      (tick_q),
    .started   (started_q),
    .steal_lat (steal_q)
);

// File: tb/tb_dram_strobe_seq.sv
module tb_dram_strobe_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phi = 1'b1;
    logic steal = 1'b0;
    logic vid_ras_n = 1'b1;
    logic vid_cas_n = 1'b1;
    logic vid_col = 1'b0;
    logic ras_n, cas_n, col_sel;

    dram_strobe_seq dut (
        .clk(clk), .rst(rst), .phi(phi), .steal(steal),
        .vid_ras_n(vid_ras_n), .vid_cas_n(vid_cas_n), .vid_col(vid_col),
        .ras_n(ras_n), .cas_n(cas_n), .col_sel(col_sel)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [2:0] exp;   // {ras_n, cas_n, col_sel}
        int         tag;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    // Bench model of the sequencer state, built from the requirements.
    int m_tick = 0;
    bit m_started = 0, m_steal = 0, m_mid = 0, m_phi_prev = 1;

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Expected levels of the processor half, taken from R3..R6.
    function automatic logic [2:0] ref_pat(input int t);
        case (t)
            0: return 3'b100;
            1, 2: return 3'b000;
            3: return 3'b110;
            4: return 3'b010;
            5: return 3'b011;
            6: return 3'b001;
            default: return 3'b110;
        endcase
    endfunction

    task automatic step(input bit r, input bit p, input bit s);
        item_t it;
        bit rise;
        @(negedge clk);
        rst = r; phi = p; steal = s;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        vid_ras_n = lfsr[0]; vid_cas_n = lfsr[3]; vid_col = lfsr[5];
        // Output after the coming edge, from the state left by the previous edge.
        if (r) begin
            it.exp = 3'b110; it.tag = 1;
        end else if (!m_started) begin
            it.exp = 3'b110; it.tag = 2;
        end else if (m_tick < 8 && !m_steal) begin
            it.exp = ref_pat(m_tick);
            if (m_mid) it.tag = 9;
            else if (m_tick == 0) it.tag = 6;
            else if (m_tick < 3) it.tag = 3;
            else if (m_tick == 3) it.tag = 4;
            else it.tag = 5;
        end else begin
            it.exp = {vid_ras_n, vid_cas_n, vid_col};
            if (m_tick >= 8) it.tag = 7;
            else if (m_mid) it.tag = 9;
            else it.tag = 8;
        end
        sb.push_back(it);
        // Model update for the coming edge.
        rise = p && !m_phi_prev;
        if (r) begin
            m_tick = 0; m_started = 0; m_steal = 0; m_mid = 0; m_phi_prev = 1;
        end else begin
            m_phi_prev = p;
            if (rise) begin
                m_tick = 0; m_started = 1; m_steal = s; m_mid = 0;
            end else begin
                if (m_tick == 7) begin
                    m_steal = s; m_mid = 0;
                end else if (s != m_steal) begin
                    m_mid = 1;
                end
                m_tick = (m_tick + 1) % 16;
            end
        end
    endtask

    // One phase period: steal is s_a before tick index chg, s_b from it on.
    task automatic period(input bit s_a, input bit s_b, input int chg);
        for (int i = 0; i < 16; i++) begin
            step(1'b0, (i < 8), (i < chg) ? s_a : s_b);
        end
    endtask

    // Monitor: pops one expected item per edge and compares mid-cycle.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if ({ras_n, cas_n, col_sel} !== it.exp) begin
                    errors++;
                    $display("FAIL %s got=%b expected=%b", tag_name(it.tag),
                             {ras_n, cas_n, col_sel}, it.exp);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0);   // R1 reset, phi high
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);   // R2 no rise yet
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);   // R2 still idle
        period(1'b0, 1'b0, 16);   // R3..R7 normal
        period(1'b0, 1'b0, 16);
        period(1'b1, 1'b1, 16);   // R8 stolen processor half
        period(1'b0, 1'b1, 3);    // R9 steal rises mid-half
        period(1'b1, 1'b0, 4);    // R9 steal drops mid-half
        period(1'b0, 1'b0, 16);   // back to normal
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
        @(posedge clk); #6;
        @(posedge clk); #6;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule